// File: doc/BRIEF.md
# Addressed Synchronous Serial Slave Port

This block is the host-facing serial port of a display controller. A host selects it with an active-low chip-select and clocks bytes over a serial clock and data line. Each transaction opens with a start byte. That byte holds a six-bit device code, a register-select flag and a read/write flag. When the code matches the port's own code, the port turns each following byte into one internal access. That access is an index load, a register write, a RAM address load, a RAM write, a status read or a RAM read. When the code does not match, the port stays silent until chip-select goes high again.

Chip-select, clock and data are brought into the system clock domain through multi-flop synchronizers, and clock edges are found from the synchronized samples. Write data is taken on the rising serial clock edge. Read data changes after each falling edge and goes out on a separate output with its own output-enable, which the pad ring combines into one bidirectional line. RAM reads use a one-cycle-latency read port and are prefetched one byte ahead. The host sees two dummy bytes before valid RAM data. A clear command makes the port busy for a programmable number of system clocks, and during that time it drops writes.

Top module: `addr_serial_port`

## Requirements
- R1: A falling chip-select starts a transaction whose first byte is the start byte, and a rising chip-select ends it. A byte cut short by chip-select rising causes no write of any kind.
- R2: The start byte goes MSB first. Its bits 7..3 are 01110, bit 2 equals `id_strap`, bit 1 is RS and bit 0 is R/W. Data bytes also go MSB first and are sampled on the rising serial clock edge.
- R3: A start byte whose upper six bits differ from {01110, `id_strap`} causes no write pulse. It also keeps `sdo_oe` low until chip-select rises.
- R4: RS=0, R/W=0: each data byte loads the 8-bit index register.
- R5: RS=1, R/W=0, with the index being none of 0x21 and 0x22: each data byte gives one `reg_wr` pulse, with `reg_addr` = index and `wr_data` = the byte.
- R6: RS=1, R/W=0 with index 0x21 loads the RAM address. With index 0x22, each byte gives one `ram_we` pulse at the current address, and the address then steps by one.
- R7: RS=1, R/W=1: the first two data bytes read 0x00. The following bytes read RAM at the address, then address+1, and so on. The address steps once for each valid byte that completes, so a later read resumes after the last byte taken. RAM read data arrives one clock after `ram_re`.
- R8: RS=0, R/W=1: every data byte reads {busy, `stat_in[6:0]`}, with busy in bit 7.
- R9: A register write to index 0x01 (the clear command) is itself performed and then sets busy for BUSY_CYC system clocks. While busy, index, register and RAM writes are dropped, and status bit 7 reads 1.
- R10: `sdo_oe` is high only in the data phase of an accepted read. It is low in all write transactions and after chip-select rises.
- R11: After reset, `sdo_oe` is low, no write pulse occurs, and the index and RAM address are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_strap | input | 1 | Strap supplying the low bit of the device code |
| cs_n | input | 1 | Serial chip-select, active low |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data into the port |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for `sdo` |
| stat_in | input | 7 | Status bits reported under the busy flag |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_addr | output | 8 | Register address (current index) |
| wr_data | output | 8 | Write data for registers and RAM |
| ram_we | output | 1 | One-cycle RAM write strobe |
| ram_re | output | 1 | One-cycle RAM read strobe |
| ram_addr | output | ADDR_W | RAM address for `ram_we` / `ram_re` |
| ram_rdata | input | 8 | RAM read data, valid one clock after `ram_re` |

## Verification
The assertions assume that the serial inputs change slowly against the system clock. Each serial clock phase must last several system clocks, so that every edge survives the synchronizers and a loaded read byte reaches `sdo` before the host samples it. They also assume that `ram_rdata` follows `ram_re` by exactly one clock. The bench keeps to this with a serial half period of ten system clocks, input changes away from the system clock edge, and a RAM model that registers its read. The busy window is widened in the bench so that a status read and a write both fit inside it.

// File: rtl/asp_pkg.sv
package asp_pkg;
   localparam int BYTE_W = 8;

   // encoding is {RS, R/W} from the start byte
   typedef enum logic [1:0] {
      ACC_IDX  = 2'b00,
      ACC_STAT = 2'b01,
      ACC_WR   = 2'b10,
      ACC_RRD  = 2'b11
   } acc_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_HDR,
      PH_DATA,
      PH_SKIP
   } phase_e;
endpackage

// File: rtl/asp_sync.sv
module asp_sync #(
   parameter int         W       = 1,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("asp_sync needs at least two stages");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stg
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/asp_bitframe.sv
module asp_bitframe
   import asp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              sclk_s,
   input  logic              sdi_s,
   input  logic              tx_load,
   input  logic [BYTE_W-1:0] tx_val,
   output logic              sel,
   output logic              f_start,
   output logic              f_end,
   output logic              byte_done,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              sdo
);
   localparam int CNT_W = $clog2(BYTE_W);

   logic              cs_d, sclk_d;
   logic              rise, fall;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-2:0] rx_sh;
   logic [BYTE_W-1:0] tx_sh;

   assign sel     = ~cs_s;
   assign f_start = cs_d & ~cs_s;
   assign f_end   = ~cs_d & cs_s;
   assign rise    = sel & ~f_start & sclk_s & ~sclk_d;
   assign fall    = sel & ~f_start & ~sclk_s & sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d   <= 1'b1;
         sclk_d <= 1'b1;
      end else begin
         cs_d   <= cs_s;
         sclk_d <= sclk_s;
      end
   end

   // receive: count bits, emit a byte on the last rising edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         rx_sh     <= '0;
         byte_done <= 1'b0;
         rx_byte   <= '0;
      end else begin
         byte_done <= 1'b0;
         if (f_start || !sel) begin
            bit_cnt <= '0;
         end else if (rise) begin
            bit_cnt <= bit_cnt + 1'b1;
            rx_sh   <= {rx_sh[BYTE_W-3:0], sdi_s};
            if (bit_cnt == CNT_W'(BYTE_W-1)) begin
               byte_done <= 1'b1;
               rx_byte   <= {rx_sh, sdi_s};
            end
         end
      end
   end

   // transmit: new bit after every falling edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh <= '0;
         sdo   <= 1'b0;
      end else if (f_start) begin
         tx_sh <= '0;
         sdo   <= 1'b0;
      end else if (tx_load) begin
         tx_sh <= tx_val;
      end else if (fall) begin
         sdo   <= tx_sh[BYTE_W-1];
         tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
   end

   a_r1_restart_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
      f_start |=> (bit_cnt == '0));
   a_r1_no_byte_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_s && $past(cs_s)) |-> !byte_done);
endmodule

// File: rtl/asp_engine.sv
module asp_engine
   import asp_pkg::*;
#(
   parameter logic [4:0]        DEV_PREFIX   = 5'b01110,
   parameter int                ADDR_W       = 8,
   parameter logic [BYTE_W-1:0] IDX_CLEAR    = 8'h01,
   parameter logic [BYTE_W-1:0] IDX_RAM_ADDR = 8'h21,
   parameter logic [BYTE_W-1:0] IDX_RAM_DATA = 8'h22,
   parameter int                BUSY_CYC     = 85
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              id_strap,
   input  logic              sel,
   input  logic              f_start,
   input  logic              f_end,
   input  logic              byte_done,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic [BYTE_W-2:0] stat_in,
   input  logic [BYTE_W-1:0] ram_rdata,
   output logic              tx_load,
   output logic [BYTE_W-1:0] tx_val,
   output logic              sdo_oe,
   output logic              reg_wr,
   output logic [BYTE_W-1:0] reg_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              ram_we,
   output logic              ram_re,
   output logic [ADDR_W-1:0] ram_addr
);
   localparam int BUSY_W = $clog2(BUSY_CYC + 1);

   if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_addr
      $error("ADDR_W must lie between 1 and the byte width");
   end
   if (BUSY_CYC < 1) begin : g_bad_busy
      $error("BUSY_CYC must be positive");
   end

   phase_e            phase;
   acc_e              acc;
   logic [1:0]        nb;
   logic [BYTE_W-1:0] index;
   logic [ADDR_W-1:0] wr_addr, rd_ptr;
   logic [BYTE_W-1:0] hold;
   logic              re_d;
   logic [BUSY_W-1:0] busy_cnt;
   logic              busy, hdr_ok;

   assign busy   = (busy_cnt != '0);
   assign hdr_ok = (rx_byte[BYTE_W-1:2] == {DEV_PREFIX, id_strap});
   assign reg_addr = index;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         acc      <= ACC_IDX;
         nb       <= '0;
         index    <= '0;
         wr_addr  <= '0;
         rd_ptr   <= '0;
         hold     <= '0;
         re_d     <= 1'b0;
         busy_cnt <= '0;
         tx_load  <= 1'b0;
         tx_val   <= '0;
         sdo_oe   <= 1'b0;
         reg_wr   <= 1'b0;
         wr_data  <= '0;
         ram_we   <= 1'b0;
         ram_re   <= 1'b0;
         ram_addr <= '0;
      end else begin
         tx_load <= 1'b0;
         reg_wr  <= 1'b0;
         ram_we  <= 1'b0;
         ram_re  <= 1'b0;
         re_d    <= ram_re;
         if (re_d) hold <= ram_rdata;
         if (busy) busy_cnt <= busy_cnt - 1'b1;

         if (f_start) begin
            phase  <= PH_HDR;
            nb     <= '0;
            sdo_oe <= 1'b0;
         end else if (f_end || !sel) begin
            phase  <= PH_IDLE;
            sdo_oe <= 1'b0;
         end else if (byte_done) begin
            unique case (phase)
               PH_HDR: begin
                  if (hdr_ok) begin
                     phase <= PH_DATA;
                     acc   <= acc_e'(rx_byte[1:0]);
                     if (rx_byte[0]) begin
                        sdo_oe  <= 1'b1;
                        tx_load <= 1'b1;
                        tx_val  <= rx_byte[1] ? '0 : {busy, stat_in};
                     end
                  end else begin
                     phase <= PH_SKIP;
                  end
               end
               PH_DATA: begin
                  unique case (acc)
                     ACC_IDX: if (!busy) index <= rx_byte;
                     ACC_WR: begin
                        if (!busy) begin
                           wr_data <= rx_byte;
                           if (index == IDX_RAM_DATA) begin
                              ram_we   <= 1'b1;
                              ram_addr <= wr_addr;
                              wr_addr  <= wr_addr + 1'b1;
                           end else if (index == IDX_RAM_ADDR) begin
                              wr_addr <= rx_byte[ADDR_W-1:0];
                           end else begin
                              reg_wr <= 1'b1;
                              if (index == IDX_CLEAR) busy_cnt <= BUSY_W'(BUSY_CYC);
                           end
                        end
                     end
                     ACC_STAT: begin
                        tx_load <= 1'b1;
                        tx_val  <= {busy, stat_in};
                     end
                     ACC_RRD: begin
                        tx_load <= 1'b1;
                        ram_re  <= 1'b1;
                        if (nb == 2'd0) begin
                           tx_val   <= '0;
                           ram_addr <= wr_addr;
                           rd_ptr   <= wr_addr + 1'b1;
                        end else begin
                           tx_val   <= hold;
                           ram_addr <= rd_ptr;
                           rd_ptr   <= rd_ptr + 1'b1;
                        end
                        if (nb == 2'd2) wr_addr <= wr_addr + 1'b1;
                        else            nb <= nb + 1'b1;
                     end
                     default: ;
                  endcase
               end
               default: ;
            endcase
         end
      end
   end

   a_r9_busy_blocks_writes: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> !(reg_wr || ram_we));
   a_r3_skip_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SKIP) |-> !(reg_wr || ram_we || sdo_oe));
   a_r10_write_never_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA && !acc[0]) |-> !sdo_oe);
   a_r10_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      f_end |=> !sdo_oe);
   a_r6_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (wr_addr == ADDR_W'(ram_addr + 1'b1)));
   a_r7_first_dummy: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_load && $rose(sdo_oe) && acc == ACC_RRD) |-> (tx_val == '0));
   a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({reg_wr, ram_we, ram_re}) <= 1);
endmodule

// File: rtl/addr_serial_port.sv
module addr_serial_port
   import asp_pkg::*;
#(
   parameter logic [4:0]        DEV_PREFIX   = 5'b01110,
   parameter int                ADDR_W       = 8,
   parameter int                SYNC_STAGES  = 2,
   parameter logic [BYTE_W-1:0] IDX_CLEAR    = 8'h01,
   parameter logic [BYTE_W-1:0] IDX_RAM_ADDR = 8'h21,
   parameter logic [BYTE_W-1:0] IDX_RAM_DATA = 8'h22,
   parameter int                BUSY_CYC     = 85
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              id_strap,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_oe,
   input  logic [BYTE_W-2:0] stat_in,
   output logic              reg_wr,
   output logic [BYTE_W-1:0] reg_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              ram_we,
   output logic              ram_re,
   output logic [ADDR_W-1:0] ram_addr,
   input  logic [BYTE_W-1:0] ram_rdata
);
   logic [2:0]        pins_s;
   logic              sel, f_start, f_end, byte_done, tx_load;
   logic [BYTE_W-1:0] rx_byte, tx_val;

   // chip-select and clock reset to their idle-high level
   asp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdi}), .q(pins_s)
   );

   asp_bitframe u_frame (
      .clk(clk), .rst_n(rst_n),
      .cs_s(pins_s[2]), .sclk_s(pins_s[1]), .sdi_s(pins_s[0]),
      .tx_load(tx_load), .tx_val(tx_val),
      .sel(sel), .f_start(f_start), .f_end(f_end),
      .byte_done(byte_done), .rx_byte(rx_byte), .sdo(sdo)
   );

   asp_engine #(
      .DEV_PREFIX(DEV_PREFIX), .ADDR_W(ADDR_W), .IDX_CLEAR(IDX_CLEAR),
      .IDX_RAM_ADDR(IDX_RAM_ADDR), .IDX_RAM_DATA(IDX_RAM_DATA), .BUSY_CYC(BUSY_CYC)
   ) u_eng (
      .clk(clk), .rst_n(rst_n), .id_strap(id_strap),
      .sel(sel), .f_start(f_start), .f_end(f_end),
      .byte_done(byte_done), .rx_byte(rx_byte),
      .stat_in(stat_in), .ram_rdata(ram_rdata),
      .tx_load(tx_load), .tx_val(tx_val), .sdo_oe(sdo_oe),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .wr_data(wr_data),
      .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr)
   );
endmodule

// File: tb/addr_serial_port_tb_top.sv
`timescale 1ns/1ps
module addr_serial_port_tb_top;
   localparam int HALF = 100;      // serial half period, ten system clocks
   localparam int BUSY = 1500;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       id_strap = 1'b0;
   logic       cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
   logic [6:0] stat_in = 7'h00;
   logic       sdo, sdo_oe, reg_wr, ram_we, ram_re;
   logic [7:0] reg_addr, wr_data, ram_addr, ram_rdata;

   int checks = 0, fails = 0;
   int reg_cnt = 0, ram_wcnt = 0;
   logic [7:0] last_addr = '0, last_data = '0;
   logic [7:0] mem [256];
   logic in_write = 1'b0, oe_bad = 1'b0, done = 1'b0;

   always #5 clk = ~clk;

   addr_serial_port #(.BUSY_CYC(BUSY)) dut_i (
      .clk(clk), .rst_n(rst_n), .id_strap(id_strap),
      .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
      .stat_in(stat_in), .reg_wr(reg_wr), .reg_addr(reg_addr), .wr_data(wr_data),
      .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr), .ram_rdata(ram_rdata)
   );

   // register sink and RAM model with one-clock read latency
   always @(posedge clk) begin
      if (reg_wr) begin
         reg_cnt   <= reg_cnt + 1;
         last_addr <= reg_addr;
         last_data <= wr_data;
      end
      if (ram_we) begin
         mem[ram_addr] <= wr_data;
         ram_wcnt      <= ram_wcnt + 1;
      end
      if (ram_re) ram_rdata <= mem[ram_addr];
      if (in_write && sdo_oe) oe_bad <= 1'b1;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] hdr(input bit id, input bit rs, input bit rw);
      return {5'b01110, id, rs, rw};
   endfunction

   task automatic xfer_bits(input logic [7:0] b, input int n, output logic [7:0] r);
      r = '0;
      for (int i = 7; i > 7 - n; i--) begin
         sclk = 1'b0; sdi = b[i];
         #(HALF);
         r[i] = sdo;
         sclk = 1'b1;
         #(HALF);
      end
   endtask

   task automatic xfer(input logic [7:0] b, output logic [7:0] r);
      xfer_bits(b, 8, r);
   endtask

   task automatic begin_txn();
      cs_n = 1'b0; #(HALF);
   endtask

   task automatic end_txn();
      #(HALF); cs_n = 1'b1; #(4*HALF);
   endtask

   task automatic wr1(input logic [7:0] h, input logic [7:0] d);
      logic [7:0] r;
      in_write = 1'b1;
      begin_txn(); xfer(h, r); xfer(d, r); end_txn();
      in_write = 1'b0;
   endtask

   task automatic t_reset();
      check(sdo_oe == 1'b0, "R11 oe after reset", sdo_oe, 0);
      check(reg_cnt == 0 && ram_wcnt == 0, "R11 no writes after reset", reg_cnt + ram_wcnt, 0);
   endtask

   task automatic t_ram_default_addr();
      logic [7:0] r;
      mem[0] = 8'h5E;
      begin_txn(); xfer(hdr(0,1,1), r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h00, r); end_txn();
      check(r == 8'h5E, "R11 RAM address starts at 0", r, 8'h5E);
   endtask

   task automatic t_reg_write();
      logic [7:0] r;
      int c0;
      wr1(hdr(0,0,0), 8'h05);
      c0 = reg_cnt;
      wr1(hdr(0,1,0), 8'hA5);
      check(reg_cnt == c0 + 1, "R5 one strobe", reg_cnt, c0 + 1);
      check(last_addr == 8'h05, "R4 index reaches reg_addr", last_addr, 8'h05);
      check(last_data == 8'hA5, "R5 write data", last_data, 8'hA5);
      in_write = 1'b1;
      begin_txn(); xfer(hdr(0,1,0), r); xfer(8'h3C, r); xfer(8'hC3, r); end_txn();
      in_write = 1'b0;
      check(reg_cnt == c0 + 3, "R5 strobe per byte", reg_cnt, c0 + 3);
      check(last_data == 8'hC3, "R2 MSB-first data", last_data, 8'hC3);
   endtask

   task automatic t_mismatch();
      logic [7:0] r;
      int c0;
      logic seen;
      c0 = reg_cnt;
      wr1(hdr(1,1,0), 8'h77);                 // wrong strap bit
      wr1({5'b01010, 1'b0, 2'b10}, 8'h77);    // wrong prefix
      check(reg_cnt == c0, "R3 mismatched code writes nothing", reg_cnt, c0);
      seen = 1'b0;
      begin_txn(); xfer(hdr(1,0,1), r);
      xfer(8'h00, r); seen = seen | sdo_oe;
      xfer(8'h00, r); seen = seen | sdo_oe;
      end_txn();
      check(seen == 1'b0, "R3 mismatched read keeps oe low", seen, 0);
   endtask

   task automatic t_strap();
      int c0;
      id_strap = 1'b1;
      #(4*HALF);
      c0 = reg_cnt;
      wr1(hdr(1,1,0), 8'h42);
      check(reg_cnt == c0 + 1 && last_data == 8'h42, "R2 strap bit sets code", last_data, 8'h42);
      wr1(hdr(0,1,0), 8'h43);
      check(reg_cnt == c0 + 1, "R2 old code rejected after strap change", reg_cnt, c0 + 1);
      id_strap = 1'b0;
      #(4*HALF);
   endtask

   task automatic t_ram_write();
      logic [7:0] r;
      int c0;
      wr1(hdr(0,0,0), 8'h21);
      wr1(hdr(0,1,0), 8'h10);
      wr1(hdr(0,0,0), 8'h22);
      c0 = ram_wcnt;
      in_write = 1'b1;
      begin_txn(); xfer(hdr(0,1,0), r); xfer(8'h11, r); xfer(8'h22, r); xfer(8'h33, r); end_txn();
      in_write = 1'b0;
      check(ram_wcnt == c0 + 3, "R6 RAM strobes", ram_wcnt, c0 + 3);
      check(mem[8'h10] == 8'h11, "R6 first RAM byte", mem[8'h10], 8'h11);
      check(mem[8'h11] == 8'h22, "R6 second RAM byte", mem[8'h11], 8'h22);
      check(mem[8'h12] == 8'h33, "R6 third RAM byte", mem[8'h12], 8'h33);
   endtask

   task automatic t_ram_read();
      logic [7:0] r;
      logic [7:0] got [5];
      for (int i = 0; i < 8; i++) mem[8'h40 + i] = 8'h90 + 8'(i * 7);
      wr1(hdr(0,0,0), 8'h21);
      wr1(hdr(0,1,0), 8'h40);
      begin_txn(); xfer(hdr(0,1,1), r);
      for (int i = 0; i < 5; i++) begin
         xfer(8'h00, got[i]);
         if (i == 0) check(sdo_oe == 1'b1, "R10 oe during read", sdo_oe, 1);
      end
      end_txn();
      check(got[0] == 8'h00, "R7 dummy byte 1", got[0], 0);
      check(got[1] == 8'h00, "R7 dummy byte 2", got[1], 0);
      check(got[2] == mem[8'h40], "R7 RAM byte at address", got[2], mem[8'h40]);
      check(got[3] == mem[8'h41], "R7 RAM byte at address+1", got[3], mem[8'h41]);
      check(got[4] == mem[8'h42], "R7 RAM byte at address+2", got[4], mem[8'h42]);
      check(sdo_oe == 1'b0, "R10 oe released", sdo_oe, 0);
      begin_txn(); xfer(hdr(0,1,1), r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h00, r); end_txn();
      check(r == mem[8'h43], "R7 next read resumes", r, mem[8'h43]);
   endtask

   task automatic t_status();
      logic [7:0] r1, r2;
      stat_in = 7'h5A;
      begin_txn(); xfer(hdr(0,0,1), r1); xfer(8'h00, r1); xfer(8'h00, r2); end_txn();
      check(r1 == 8'h5A && r2 == 8'h5A, "R8 status idle", r1, 8'h5A);
   endtask

   task automatic t_busy();
      logic [7:0] r;
      int c0;
      wr1(hdr(0,0,0), 8'h01);
      c0 = reg_cnt;
      wr1(hdr(0,1,0), 8'h01);                 // clear command
      check(reg_cnt == c0 + 1 && last_addr == 8'h01, "R9 clear itself written", last_addr, 8'h01);
      begin_txn(); xfer(hdr(0,0,1), r); xfer(8'h00, r); end_txn();
      check(r == 8'hDA, "R9 busy flag in status", r, 8'hDA);
      wr1(hdr(0,1,0), 8'h66);
      check(reg_cnt == c0 + 1, "R9 write dropped while busy", reg_cnt, c0 + 1);
      #(BUSY * 10);
      begin_txn(); xfer(hdr(0,0,1), r); xfer(8'h00, r); end_txn();
      check(r == 8'h5A, "R9 busy cleared", r, 8'h5A);
      wr1(hdr(0,0,0), 8'h07);
      wr1(hdr(0,1,0), 8'h99);
      check(reg_cnt == c0 + 2 && last_addr == 8'h07 && last_data == 8'h99,
            "R9 write accepted after busy", last_data, 8'h99);
   endtask

   task automatic t_partial();
      logic [7:0] r;
      int c0;
      wr1(hdr(0,0,0), 8'h08);
      c0 = reg_cnt;
      in_write = 1'b1;
      begin_txn(); xfer(hdr(0,1,0), r); xfer_bits(8'hF0, 4, r); end_txn();
      in_write = 1'b0;
      check(reg_cnt == c0, "R1 partial byte discarded", reg_cnt, c0);
      wr1(hdr(0,1,0), 8'h5C);
      check(reg_cnt == c0 + 1 && last_data == 8'h5C, "R1 new frame after cut", last_data, 8'h5C);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      ram_rdata = 8'h00;
      #100 rst_n = 1'b1;
      #100;
      t_reset();
      t_ram_default_addr();
      t_reg_write();
      t_mismatch();
      t_strap();
      t_ram_write();
      t_ram_read();
      t_status();
      t_busy();
      t_partial();
      check(oe_bad == 1'b0, "R10 oe low in all writes", oe_bad, 0);
      finish_run();
   end
endmodule